// File: doc/BRIEF.md
# Floating-Point Dispatch Interlock

This block sits between an integer pipeline and a coprocessor floating-point unit. It holds the one floating-point operation currently executing in a single-entry in-flight queue. The integer pipeline keeps issuing integer work while that operation runs. A second floating-point instruction that arrives while the entry is occupied stalls the integer pipeline. The stall lasts until the floating-point unit signals completion with a done pulse. The arithmetic itself is not part of the block, and the done pulse may arrive after any latency.

Source operands of the decoding floating-point instruction are compared against the destination of the queued operation. A match raises an FPU hold one cycle later. A global memory hold freezes the whole block. While it is high, nothing is accepted, completion is not processed, and the stall and hold outputs keep the values they had before the hold began.

Top module: `fpu_dispatch_interlock`

## Requirements
- R1: After reset the queue is empty (`q_busy`=0, `q_tag`=0, `q_dst`=0) and `int_stall` and `fp_hold` are 0.
- R2: A dispatch seen while the queue is empty and `mem_hold` is 0 is accepted without stall. After the next rising edge, `q_busy`=1 and `q_tag`/`q_dst` hold the dispatched tag and destination.
- R3: A dispatch seen while the queue is occupied, with no done pulse in the same cycle, raises `int_stall` in that same cycle. The queue contents stay unchanged.
- R4: A done pulse while the queue is occupied empties it at the next rising edge. A done pulse while the queue is empty has no effect.
- R5: A dispatch in the same cycle as a done pulse on an occupied queue is not stalled, and the new operation replaces the old one at the next edge.
- R6: A stalled dispatch with a source index equal to `q_dst` raises `fp_hold` one cycle later, never in the same cycle. Sources are packed in `disp_src`, with source 0 in the lowest `REG_W` bits.
- R7: `fp_hold` is 0 in the cycle after the queue empties or a done pulse is seen.
- R8: While `mem_hold` is 1, no dispatch is accepted and done pulses are ignored. `q_busy`, `q_tag`, `q_dst` and `fp_hold` do not change.
- R9: While `mem_hold` is 1, `int_stall` shows the stall value from the last cycle before the hold started.
- R10: The queue stays occupied for any completion latency; both a 4-cycle and a 17-cycle done pulse are handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | A floating-point instruction is in decode |
| disp_tag | input | TAG_W | Opcode tag of the decoding instruction |
| disp_src | input | NUM_SRC*REG_W | Packed source register indices |
| disp_dst | input | REG_W | Destination register index |
| fpu_done | input | 1 | Completion pulse for the queued operation |
| mem_hold | input | 1 | Global freeze |
| int_stall | output | 1 | Stall to the integer pipeline |
| fp_hold | output | 1 | Operand-dependency hold |
| q_busy | output | 1 | Queue entry occupied |
| q_tag | output | TAG_W | Tag of queued operation |
| q_dst | output | REG_W | Destination of queued operation |

## Verification
The main function is exercised with four patterns: a dispatch into an empty queue, repeated independent dispatches into a busy queue, a dispatch that coincides with completion, and a dependent dispatch that matches the queued destination. Together these separate the stall path from the accept path and the same-cycle handover from a late one. They also show that the dependency hold comes one cycle late. A memory hold is applied while both stall and hold are high and a done pulse is present, which shows that the freeze overrides completion. Completion latencies of 4 and 17 cycles, and a done pulse on an empty queue, cover the latency boundaries.

// File: rtl/fdq_pkg.sv
package fdq_pkg;
    localparam int DEF_TAG_W   = 6;
    localparam int DEF_REG_W   = 5;
    localparam int DEF_NUM_SRC = 2;
endpackage

// File: rtl/fdq_dep_match.sv
module fdq_dep_match #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC*REG_W-1:0] src,
    input  logic [REG_W-1:0]         dst,
    output logic                     hit
);
    logic [NUM_SRC-1:0] eq;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
        assign eq[i] = (src[i*REG_W +: REG_W] == dst);
    end

    assign hit = |eq;
endmodule

// File: rtl/fdq_accept.sv
module fdq_accept (
    input  logic valid,
    input  logic busy,
    input  logic done,
    input  logic mem_hold,
    output logic done_eff,
    output logic stall_live,
    output logic accept
);
    always_comb begin
        stall_live = valid & busy & ~done;
        done_eff   = done & busy & ~mem_hold;
        accept     = valid & ~mem_hold & ~stall_live;
    end
endmodule

// File: rtl/fpu_dispatch_interlock.sv
module fpu_dispatch_interlock #(
    parameter int TAG_W   = fdq_pkg::DEF_TAG_W,
    parameter int REG_W   = fdq_pkg::DEF_REG_W,
    parameter int NUM_SRC = fdq_pkg::DEF_NUM_SRC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     disp_valid,
    input  logic [TAG_W-1:0]         disp_tag,
    input  logic [NUM_SRC*REG_W-1:0] disp_src,
    input  logic [REG_W-1:0]         disp_dst,
    input  logic                     fpu_done,
    input  logic                     mem_hold,
    output logic                     int_stall,
    output logic                     fp_hold,
    output logic                     q_busy,
    output logic [TAG_W-1:0]         q_tag,
    output logic [REG_W-1:0]         q_dst
);
    typedef struct packed {
        logic             busy;
        logic [TAG_W-1:0] tag;
        logic [REG_W-1:0] dst;
        logic             hold;
        logic             frz_stall;
    } state_t;

    state_t state_q, state_d;
    logic   dep_hit, done_eff, stall_live, accept;

    fdq_dep_match #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_dep (
        .src (disp_src),
        .dst (state_q.dst),
        .hit (dep_hit)
    );

    fdq_accept u_acc (
        .valid      (disp_valid),
        .busy       (state_q.busy),
        .done       (fpu_done),
        .mem_hold   (mem_hold),
        .done_eff   (done_eff),
        .stall_live (stall_live),
        .accept     (accept)
    );

    always_comb begin
        state_d = state_q;
        if (!mem_hold) begin
            state_d.frz_stall = stall_live;
            state_d.hold      = stall_live & dep_hit;
            if (done_eff) begin
                state_d.busy = 1'b0;
            end
            if (accept) begin
                state_d.busy = 1'b1;
                state_d.tag  = disp_tag;
                state_d.dst  = disp_dst;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign int_stall = mem_hold ? state_q.frz_stall : stall_live;
    assign fp_hold   = state_q.hold;
    assign q_busy    = state_q.busy;
    assign q_tag     = state_q.tag;
    assign q_dst     = state_q.dst;
endmodule

// File: rtl/fdq_checker.sv
module fdq_checker #(
    parameter int TAG_W   = 6,
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     disp_valid,
    input logic [TAG_W-1:0]         disp_tag,
    input logic [NUM_SRC*REG_W-1:0] disp_src,
    input logic [REG_W-1:0]         disp_dst,
    input logic                     fpu_done,
    input logic                     mem_hold,
    input logic                     int_stall,
    input logic                     fp_hold,
    input logic                     q_busy,
    input logic [TAG_W-1:0]         q_tag,
    input logic [REG_W-1:0]         q_dst
);
    AST_STALL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_hold && int_stall) |-> q_busy); // R3

    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_hold && disp_valid && !int_stall) |=> (q_busy && q_tag == $past(disp_tag))); // R2

    AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_hold && fpu_done && q_busy && !disp_valid) |=> !q_busy); // R4

    AST_HOLD_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fp_hold) |-> $past(disp_valid && q_busy && !mem_hold)); // R6

    AST_HOLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_hold && (!q_busy || fpu_done)) |=> !fp_hold); // R7

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hold |=> ($stable(q_busy) && $stable(q_tag) && $stable(q_dst) && $stable(fp_hold))); // R8
endmodule

bind fpu_dispatch_interlock fdq_checker #(.TAG_W(TAG_W), .REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .disp_src(disp_src), .disp_dst(disp_dst), .fpu_done(fpu_done), .mem_hold(mem_hold),
    .int_stall(int_stall), .fp_hold(fp_hold), .q_busy(q_busy), .q_tag(q_tag), .q_dst(q_dst)
);

// File: tb/tb_fpu_dispatch_interlock.sv
module tb_fpu_dispatch_interlock;
    localparam int TW = 6;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          disp_valid = 1'b0;
    logic [TW-1:0] disp_tag = '0;
    logic [2*RW-1:0] disp_src = '0;
    logic [RW-1:0] disp_dst = '0;
    logic          fpu_done = 1'b0;
    logic          mem_hold = 1'b0;
    logic          int_stall, fp_hold, q_busy;
    logic [TW-1:0] q_tag;
    logic [RW-1:0] q_dst;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fpu_dispatch_interlock #(.TAG_W(TW), .REG_W(RW), .NUM_SRC(2)) dut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tag(disp_tag),
        .disp_src(disp_src), .disp_dst(disp_dst), .fpu_done(fpu_done), .mem_hold(mem_hold),
        .int_stall(int_stall), .fp_hold(fp_hold), .q_busy(q_busy), .q_tag(q_tag), .q_dst(q_dst)
    );

    typedef struct {
        string         req;
        bit            stall;
        bit            busy;
        bit [TW-1:0]   tag;
        bit [RW-1:0]   dst;
        bit            hold;
    } exp_t;

    exp_t sb[$];

    bit          m_busy = 0, m_hold = 0, m_frz = 0;
    bit [TW-1:0] m_tag = 0;
    bit [RW-1:0] m_dst = 0;

    task automatic chk(string r, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, expv);
        end
    endtask

    task automatic cyc(string r, bit v, bit [TW-1:0] tg, bit [RW-1:0] sa, bit [RW-1:0] sbb,
                       bit [RW-1:0] dd, bit dn, bit mh);
        exp_t e;
        bit live;
        @(negedge clk);
        disp_valid = v; disp_tag = tg; disp_src = {sbb, sa}; disp_dst = dd;
        fpu_done = dn; mem_hold = mh;
        live = v && m_busy && !dn;
        e.req = r;
        e.stall = mh ? m_frz : live;
        if (!mh) begin
            m_frz  = live;
            m_hold = live && (sa == m_dst || sbb == m_dst);
            if (dn && m_busy) m_busy = 0;
            if (v && !live) begin
                m_busy = 1; m_tag = tg; m_dst = dd;
            end
        end
        e.busy = m_busy; e.tag = m_tag; e.dst = m_dst; e.hold = m_hold;
        sb.push_back(e);
    endtask

    task automatic idle(string r, int n);
        for (int i = 0; i < n; i++) cyc(r, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // monitor: comb stall mid-cycle, registered state after the edge
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() != 0) begin
                it = sb.pop_front();
                chk(it.req, "int_stall", int'(int_stall), int'(it.stall));
                @(posedge clk);
                #1;
                chk(it.req, "q_busy", int'(q_busy), int'(it.busy));
                chk(it.req, "q_tag", int'(q_tag), int'(it.tag));
                chk(it.req, "q_dst", int'(q_dst), int'(it.dst));
                chk(it.req, "fp_hold", int'(fp_hold), int'(it.hold));
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset q_busy", int'(q_busy), 0);
        chk("R1", "reset fp_hold", int'(fp_hold), 0);
        chk("R1", "reset int_stall", int'(int_stall), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1", 2);
        // R2 accept into empty queue; R10 4-cycle latency
        cyc("R2", 1, 5, 1, 2, 3, 0, 0);
        idle("R10", 3);
        cyc("R10_R4", 0, 0, 0, 0, 0, 1, 0);
        cyc("R4", 0, 0, 0, 0, 0, 1, 0);          // done on empty queue ignored
        cyc("R2", 1, 6, 1, 2, 7, 0, 0);
        // R3 independent dispatch into busy queue
        for (int i = 0; i < 3; i++) cyc("R3", 1, 9, 8, 9, 10, 0, 0);
        // R5 dispatch together with done
        cyc("R5", 1, 9, 8, 9, 10, 1, 0);
        // R6 dependent dispatch (source 0 equals queued dst 10)
        for (int i = 0; i < 3; i++) cyc("R6", 1, 11, 10, 0, 12, 0, 0);
        // R8 R9 freeze with done and dispatch present
        cyc("R8_R9", 1, 11, 10, 0, 12, 1, 1);
        cyc("R8_R9", 1, 11, 10, 0, 12, 1, 1);
        cyc("R9", 0, 0, 0, 0, 0, 0, 1);
        // R7 release, done with dispatch: hold drops
        cyc("R7", 1, 11, 10, 0, 12, 1, 0);
        // R10 17-cycle latency
        idle("R10", 16);
        cyc("R10", 0, 0, 0, 0, 0, 1, 0);
        // dependency on source 1
        cyc("R2", 1, 20, 1, 1, 4, 0, 0);
        cyc("R6", 1, 21, 0, 4, 2, 0, 0);
        cyc("R7", 0, 0, 0, 0, 0, 1, 0);
        idle("R7", 2);
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule